// File: doc/BRIEF.md
# Interprocessor Mailbox and Vectored Interrupt Registers

This block sits inside one processor of a shared-bus multiprocessor and gives whichever processor currently owns the bus a way to talk to it. It holds a bank of general-purpose message words, eight by default, and one vector word. The bus owner can read or write any of them through the bus-side port. A write can target one processor through its select line, or every processor at once through the broadcast line. Broadcast writes keep a shared semaphore word identical in every copy of the block.

Writing an address into the vector word raises a high-priority interrupt toward the local core. The written address is presented as the branch target. The local core reads the words through its own port, clears message words once it has consumed them, and acknowledges the interrupt when it takes it. A second vector write that arrives before the acknowledge replaces the target and records a sticky overrun. Only one interrupt stays pending.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every message word reads 0, the vector word reads VEC_RESET (default 0), and `irq_pend` and `irq_ovr` are 0.
- R2: A bus write to word address a, with 0 <= a < NUM_MSG, `bus_we`=1 and `bus_sel`=1, stores `bus_wdata` into message word a at the next rising clock edge.
- R3: With `bus_sel`=1, `bus_rdata` returns the word at `bus_addr` combinationally (address NUM_MSG is the vector word). It returns 0 for any address above NUM_MSG or when `bus_sel`=0.
- R4: A write with `bus_bcast`=1 takes effect even when `bus_sel`=0.
- R5: A write with both `bus_sel` and `bus_bcast` low has no effect. A write to an address above NUM_MSG has no effect.
- R6: A bus write to address NUM_MSG sets `irq_pend` at the next edge, and `irq_vec` then equals the written data.
- R7: `irq_pend` stays set until a cycle with `loc_ack`=1, and it is 0 after that edge. If a vector write occurs in the same cycle as the acknowledge, `irq_pend` stays 1.
- R8: A vector write while `irq_pend`=1 and `loc_ack`=0 replaces `irq_vec` and sets `irq_ovr`. The overrun flag is sticky. A single acknowledge clears the pending interrupt.
- R9: `loc_clr`=1 with `loc_addr` < NUM_MSG zeroes that message word. `loc_clr`=1 with `loc_addr`=NUM_MSG clears `irq_ovr` and leaves `irq_vec` unchanged.
- R10: When a bus write and a local clear hit the same message word in one cycle, the bus data is stored. A clear of a different word in that cycle still takes effect.
- R11: `loc_rdata` returns the word at `loc_addr` combinationally, and returns 0 above NUM_MSG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus-side word address (NUM_MSG = vector word) |
| bus_wdata | input | DATA_W | Bus-side write data |
| bus_we | input | 1 | Bus-side write strobe |
| bus_sel | input | 1 | This processor is addressed |
| bus_bcast | input | 1 | Broadcast write to all processors |
| bus_rdata | output | DATA_W | Bus-side read data |
| loc_addr | input | ADDR_W | Local-side word address |
| loc_clr | input | 1 | Local clear of the addressed word or the overrun flag |
| loc_ack | input | 1 | Local interrupt acknowledge |
| loc_rdata | output | DATA_W | Local-side read data |
| irq_pend | output | 1 | Vectored interrupt pending |
| irq_vec | output | DATA_W | Interrupt branch target |
| irq_ovr | output | 1 | Sticky overrun flag |

## Verification
Stored words, `irq_pend`, `irq_vec` and `irq_ovr` change at the single rising edge that samples the write, clear or acknowledge. Both read ports are combinational and follow the address within the same cycle. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It reads the state at that second falling edge, which is exactly one rising edge after the stimulus. For read checks it sets the address and waits a short settle delay before sampling, with no clock edge in between.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

   typedef enum logic {
      RD_COMB = 1'b0,
      RD_REG  = 1'b1
   } rd_mode_e;

   function automatic int word_addr_w(input int num_msg);
      return (num_msg < 1) ? 1 : $clog2(num_msg + 1);
   endfunction

endpackage

// File: rtl/ipc_mbx_decode.sv
module ipc_mbx_decode #(
   parameter int NUM_MSG = 8,
   parameter int ADDR_W  = 4
) (
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic               bus_sel,
   input  logic               bus_bcast,
   input  logic [ADDR_W-1:0]  loc_addr,
   input  logic               loc_clr,
   output logic [NUM_MSG-1:0] bus_wen,
   output logic [NUM_MSG-1:0] loc_cen,
   output logic               vec_wr,
   output logic               ovr_clr
);

   localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(NUM_MSG);

   logic wr_ok;

   assign wr_ok   = bus_we & (bus_sel | bus_bcast);
   assign vec_wr  = wr_ok & (bus_addr == VEC_ADDR);
   assign ovr_clr = loc_clr & (loc_addr == VEC_ADDR);

   for (genvar i = 0; i < NUM_MSG; i++) begin : g_dec
      assign bus_wen[i] = wr_ok & (bus_addr == ADDR_W'(i));
      assign loc_cen[i] = loc_clr & (loc_addr == ADDR_W'(i));
   end

endmodule

// File: rtl/ipc_mbx_regfile.sv
module ipc_mbx_regfile #(
   parameter int NUM_MSG = 8,
   parameter int DATA_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_MSG-1:0]        bus_wen,
   input  logic [NUM_MSG-1:0]        loc_cen,
   input  logic [DATA_W-1:0]         wdata,
   output logic [NUM_MSG*DATA_W-1:0] msg_flat
);

   for (genvar i = 0; i < NUM_MSG; i++) begin : g_word
      logic [DATA_W-1:0] word_q;

      // bus write has priority over a same-cycle local clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          word_q <= '0;
         else if (bus_wen[i]) word_q <= wdata;
         else if (loc_cen[i]) word_q <= '0;
      end

      assign msg_flat[i*DATA_W +: DATA_W] = word_q;
   end

endmodule

// File: rtl/ipc_mbx_vector.sv
module ipc_mbx_vector #(
   parameter int          DATA_W    = 32,
   parameter logic [63:0] VEC_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] vec_q,
   output logic              pend_q,
   output logic              ovr_q
);

   logic ovr_set;

   assign ovr_set = vec_wr & pend_q & ~ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vec_q <= VEC_RESET[DATA_W-1:0];
      else if (vec_wr) vec_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (vec_wr) pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
   end

endmodule

// File: rtl/ipc_mbx_rdmux.sv
module ipc_mbx_rdmux #(
   parameter int NUM_WORDS = 9,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 4
) (
   input  logic [NUM_WORDS*DATA_W-1:0] words_flat,
   input  logic [IDX_W-1:0]            idx,
   input  logic                        en,
   output logic [DATA_W-1:0]           data
);

   always_comb begin
      data = '0;
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (en && (idx == IDX_W'(k))) data = words_flat[k*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbx_pkg::*;
#(
   parameter int          NUM_MSG   = 8,
   parameter int          DATA_W    = 32,
   parameter rd_mode_e    RD_MODE   = RD_COMB,
   parameter logic [63:0] VEC_RESET = '0,
   localparam int         ADDR_W    = word_addr_w(NUM_MSG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_sel,
   input  logic              bus_bcast,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic              loc_clr,
   input  logic              loc_ack,
   output logic [DATA_W-1:0] loc_rdata,
   output logic              irq_pend,
   output logic [DATA_W-1:0] irq_vec,
   output logic              irq_ovr
);

   localparam int NUM_WORDS = NUM_MSG + 1;

   if (NUM_MSG < 1 || NUM_MSG > 64) begin : g_bad_num
      $error("ipc_mailbox: NUM_MSG must lie in 1..64");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("ipc_mailbox: DATA_W must lie in 1..64");
   end

   logic [NUM_MSG-1:0]          bus_wen;
   logic [NUM_MSG-1:0]          loc_cen;
   logic                        vec_wr;
   logic                        ovr_clr;
   logic [NUM_MSG*DATA_W-1:0]   msg_flat;
   logic [NUM_WORDS*DATA_W-1:0] words_flat;
   logic [DATA_W-1:0]           bus_rd_raw;

   ipc_mbx_decode #(.NUM_MSG(NUM_MSG), .ADDR_W(ADDR_W)) u_decode (
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_sel   (bus_sel),
      .bus_bcast (bus_bcast),
      .loc_addr  (loc_addr),
      .loc_clr   (loc_clr),
      .bus_wen   (bus_wen),
      .loc_cen   (loc_cen),
      .vec_wr    (vec_wr),
      .ovr_clr   (ovr_clr)
   );

   ipc_mbx_regfile #(.NUM_MSG(NUM_MSG), .DATA_W(DATA_W)) u_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wen  (bus_wen),
      .loc_cen  (loc_cen),
      .wdata    (bus_wdata),
      .msg_flat (msg_flat)
   );

   ipc_mbx_vector #(.DATA_W(DATA_W), .VEC_RESET(VEC_RESET)) u_vector (
      .clk     (clk),
      .rst_n   (rst_n),
      .vec_wr  (vec_wr),
      .wdata   (bus_wdata),
      .ack     (loc_ack),
      .ovr_clr (ovr_clr),
      .vec_q   (irq_vec),
      .pend_q  (irq_pend),
      .ovr_q   (irq_ovr)
   );

   assign words_flat = {irq_vec, msg_flat};

   ipc_mbx_rdmux #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(ADDR_W)) u_bus_rd (
      .words_flat (words_flat),
      .idx        (bus_addr),
      .en         (bus_sel),
      .data       (bus_rd_raw)
   );

   ipc_mbx_rdmux #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(ADDR_W)) u_loc_rd (
      .words_flat (words_flat),
      .idx        (loc_addr),
      .en         (1'b1),
      .data       (loc_rdata)
   );

   if (RD_MODE == RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= bus_rd_raw;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd_raw;
   end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
   parameter int NUM_MSG = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [DATA_W-1:0]         bus_wdata,
   input logic                      bus_we,
   input logic                      bus_sel,
   input logic                      bus_bcast,
   input logic [ADDR_W-1:0]         loc_addr,
   input logic                      loc_clr,
   input logic                      loc_ack,
   input logic                      irq_pend,
   input logic [DATA_W-1:0]         irq_vec,
   input logic                      irq_ovr,
   input logic [NUM_MSG*DATA_W-1:0] msg_flat
);

   logic wr_go;
   logic msg_wr;
   logic vwr;
   logic vclr;

   assign wr_go  = bus_we && (bus_sel || bus_bcast);
   assign msg_wr = wr_go && (int'(bus_addr) < NUM_MSG);
   assign vwr    = wr_go && (int'(bus_addr) == NUM_MSG);
   assign vclr   = loc_clr && (int'(loc_addr) == NUM_MSG);

   assert_msg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      msg_wr |=> msg_flat[int'($past(bus_addr))*DATA_W +: DATA_W] == $past(bus_wdata));

   assert_bus_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_wr && loc_clr && loc_addr == bus_addr)
      |=> msg_flat[int'($past(bus_addr))*DATA_W +: DATA_W] == $past(bus_wdata));

   assert_ignored_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_sel && !bus_bcast && !loc_clr) |=> $stable(msg_flat) && $stable(irq_vec));

   assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vwr |=> irq_pend && (irq_vec == $past(bus_wdata)));

   assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_ack && !vwr) |=> !irq_pend);

   assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !loc_ack) |=> irq_pend);

   assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vwr && irq_pend && !loc_ack) |=> irq_ovr);

   assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ovr && !vclr) |=> irq_ovr);

   assert_local_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_clr && int'(loc_addr) < NUM_MSG && !(msg_wr && bus_addr == loc_addr))
      |=> msg_flat[int'($past(loc_addr))*DATA_W +: DATA_W] == '0);

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
   .NUM_MSG (NUM_MSG),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_sel   (bus_sel),
   .bus_bcast (bus_bcast),
   .loc_addr  (loc_addr),
   .loc_clr   (loc_clr),
   .loc_ack   (loc_ack),
   .irq_pend  (irq_pend),
   .irq_vec   (irq_vec),
   .irq_ovr   (irq_ovr),
   .msg_flat  (msg_flat)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

   localparam int NUM_MSG = 8;
   localparam int DATA_W  = 32;
   localparam int ADDR_W  = 4;
   localparam int VEC_A   = NUM_MSG;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic              bus_we = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_bcast = 1'b0;
   logic [DATA_W-1:0] bus_rdata;
   logic [ADDR_W-1:0] loc_addr = '0;
   logic              loc_clr = 1'b0;
   logic              loc_ack = 1'b0;
   logic [DATA_W-1:0] loc_rdata;
   logic              irq_pend;
   logic [DATA_W-1:0] irq_vec;
   logic              irq_ovr;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [DATA_W-1:0] model [NUM_MSG];

   always #2.5 clk = ~clk;

   ipc_mailbox uut (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .bus_sel(bus_sel), .bus_bcast(bus_bcast), .bus_rdata(bus_rdata),
      .loc_addr(loc_addr), .loc_clr(loc_clr), .loc_ack(loc_ack),
      .loc_rdata(loc_rdata), .irq_pend(irq_pend), .irq_vec(irq_vec),
      .irq_ovr(irq_ovr)
   );

   task automatic check(input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input logic [DATA_W-1:0] d,
                            input logic sel, input logic bc);
      @(negedge clk);
      bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
      bus_sel = sel; bus_bcast = bc;
      @(negedge clk);
      bus_we = 1'b0; bus_sel = 1'b0; bus_bcast = 1'b0;
   endtask

   task automatic bus_read(input int a, input logic [DATA_W-1:0] exp, input string req);
      bus_addr = ADDR_W'(a); bus_sel = 1'b1;
      #1 check(req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic loc_read(input int a, input logic [DATA_W-1:0] exp, input string req);
      loc_addr = ADDR_W'(a);
      #1 check(req, loc_rdata, exp);
   endtask

   task automatic loc_pulse(input int a, input logic clr, input logic ack);
      @(negedge clk);
      loc_addr = ADDR_W'(a); loc_clr = clr; loc_ack = ack;
      @(negedge clk);
      loc_clr = 1'b0; loc_ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 pend", {31'd0, irq_pend}, '0);
      check("R1 ovr", {31'd0, irq_ovr}, '0);
      check("R1 vec", irq_vec, '0);
      for (int i = 0; i < NUM_MSG; i++) loc_read(i, '0, "R1 msg");
   endtask

   task automatic t_msg_rw();
      for (int i = 0; i < NUM_MSG; i++) begin
         model[i] = 32'hA500_0000 ^ (32'h0101_0101 * (i + 1));
         bus_write(i, model[i], 1'b1, 1'b0);
      end
      for (int i = 0; i < NUM_MSG; i++) bus_read(i, model[i], "R2 R3 bus readback");
      for (int i = NUM_MSG - 1; i >= 0; i--) loc_read(i, model[i], "R11 local readback");
      bus_read(9, '0, "R3 out of range");
      loc_read(15, '0, "R11 out of range");
      bus_addr = ADDR_W'(2); bus_sel = 1'b0;
      #1 check("R3 unselected read", bus_rdata, '0);
   endtask

   task automatic t_ignored();
      bus_write(3, 32'hDEAD_BEEF, 1'b0, 1'b0);
      loc_read(3, model[3], "R5 unselected write");
      bus_write(12, 32'h1234_5678, 1'b1, 1'b0);
      for (int i = 0; i < NUM_MSG; i++) loc_read(i, model[i], "R5 high address");
      check("R5 no irq", {31'd0, irq_pend}, '0);
   endtask

   task automatic t_bcast();
      model[5] = 32'h0BCA_5705;
      bus_write(5, model[5], 1'b0, 1'b1);
      loc_read(5, model[5], "R4 broadcast");
   endtask

   task automatic t_vector();
      bus_write(VEC_A, 32'h0000_4000, 1'b1, 1'b0);
      check("R6 pend", {31'd0, irq_pend}, 32'd1);
      check("R6 vec", irq_vec, 32'h0000_4000);
      bus_read(VEC_A, 32'h0000_4000, "R3 vector read");
      repeat (3) @(negedge clk);
      check("R7 hold", {31'd0, irq_pend}, 32'd1);
      loc_pulse(0, 1'b0, 1'b1);
      check("R7 ack", {31'd0, irq_pend}, '0);
      check("R7 no ovr", {31'd0, irq_ovr}, '0);
   endtask

   task automatic t_overrun();
      bus_write(VEC_A, 32'h0000_1111, 1'b1, 1'b0);
      bus_write(VEC_A, 32'h0000_2222, 1'b1, 1'b0);
      check("R8 vec replaced", irq_vec, 32'h0000_2222);
      check("R8 ovr", {31'd0, irq_ovr}, 32'd1);
      loc_pulse(0, 1'b0, 1'b1);
      check("R8 single ack", {31'd0, irq_pend}, '0);
      check("R8 sticky", {31'd0, irq_ovr}, 32'd1);
      loc_pulse(VEC_A, 1'b1, 1'b0);
      check("R9 ovr clear", {31'd0, irq_ovr}, '0);
      check("R9 vec kept", irq_vec, 32'h0000_2222);
   endtask

   task automatic t_ack_collide();
      bus_write(VEC_A, 32'h0000_3333, 1'b1, 1'b0);
      @(negedge clk);
      bus_addr = ADDR_W'(VEC_A); bus_wdata = 32'h0000_4444; bus_we = 1'b1;
      bus_sel = 1'b1; loc_ack = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_sel = 1'b0; loc_ack = 1'b0;
      check("R7 write beats ack", {31'd0, irq_pend}, 32'd1);
      check("R7 new vec", irq_vec, 32'h0000_4444);
      check("R8 no ovr on ack", {31'd0, irq_ovr}, '0);
      loc_pulse(0, 1'b0, 1'b1);
   endtask

   task automatic t_clear();
      loc_pulse(2, 1'b1, 1'b0);
      model[2] = '0;
      loc_read(2, '0, "R9 clear");
      loc_read(1, model[1], "R9 neighbour kept");
   endtask

   task automatic t_collide();
      @(negedge clk);
      bus_addr = ADDR_W'(4); bus_wdata = 32'h0C0F_FEE4; bus_we = 1'b1; bus_sel = 1'b1;
      loc_addr = ADDR_W'(4); loc_clr = 1'b1;
      @(negedge clk);
      model[4] = 32'h0C0F_FEE4;
      bus_addr = ADDR_W'(6); bus_wdata = 32'h0000_0666;
      loc_addr = ADDR_W'(1);
      @(negedge clk);
      model[6] = 32'h0000_0666; model[1] = '0;
      bus_we = 1'b0; bus_sel = 1'b0; loc_clr = 1'b0;
      loc_read(4, model[4], "R10 bus wins");
      loc_read(6, model[6], "R10 other write");
      loc_read(1, '0, "R10 other clear");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_msg_rw();
      t_ignored();
      t_bcast();
      t_vector();
      t_overrun();
      t_ack_collide();
      t_clear();
      t_collide();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule